// File: doc/BRIEF.md
# Gate Drive Protection Sequencer

This block is the digital control core on the output side of a single-channel isolated gate driver. It reads two command pins of opposite polarity and four comparator flags: input supply low, output supply low, die too hot, and gate voltage below the clamp reference. It drives three enables: one for the pull-up switch, one for the main pull-down switch, and one for the Miller clamp switch.

The two command pins combine into a single drive request. Any supply or thermal fault overrides the request and parks the output low. A one-cycle dead interval separates every change between pull-up and pull-down. When the gate turns off, the clamp switch is held open at first. It latches closed once the gate has fallen below the reference, and it stays closed until the next turn-on request or a fault. A build parameter removes the thermal shutdown path for variants that lack the sensor.

Top module: `gate_drive_seq`

## Requirements
- R1: The drive request is high only when `cmd_pos`=1 and `cmd_neg`=0. The other three combinations leave the gate low, with `pd_en`=1 and `pu_en`=0.
- R2: If either `uv_in` or `uv_out` is 1, `pu_en` is 0 on the next clock, whatever the command pins are.
- R3: Once both supply flags are back to 0, the output follows the drive request again.
- R4: With `OTP_EN`=1, `hot` forces the gate low (`pu_en`=0 on the next clock) for as long as it stays 1. Normal drive returns after it clears.
- R5: With `OTP_EN`=0, `hot` has no effect on any output.
- R6: At the start of a turn-off the clamp is open. In the first cycle after a high-to-low request, `pu_en`=0, `pd_en`=0 and `clamp_en`=0. After that, `pd_en`=1.
- R7: While the gate is off (pull-up off, no fault), `gate_low`=1 sets `clamp_en` to 1 on the next clock. It then stays 1 even after `gate_low` returns to 0. A `gate_low` seen while the request is high does not set it.
- R8: The latched clamp releases when the drive request goes from low to high: `clamp_en` is 0 on the clock that starts the turn-on. `clamp_en` is never 1 while `pu_en` is 1.
- R9: `pu_en` and `pd_en` are never both 1. Each state change passes through exactly one cycle in which both are 0.
- R10: During and after reset, `pu_en`=0, `pd_en`=1 and `clamp_en`=0. No request is honoured until both supply flags read 0.
- R11: A fault clears the clamp latch. After the fault, the latch stays clear until `gate_low` is seen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_pos | input | 1 | Non-inverting command pin |
| cmd_neg | input | 1 | Inverting command pin |
| uv_in | input | 1 | Input-side supply below lockout |
| uv_out | input | 1 | Output-side supply below lockout |
| hot | input | 1 | Over-temperature flag |
| gate_low | input | 1 | Gate sense below the clamp reference |
| pu_en | output | 1 | Pull-up switch enable |
| pd_en | output | 1 | Main pull-down switch enable |
| clamp_en | output | 1 | Miller clamp switch enable |

## Verification
The bench checks that the clamp does not close in the dead cycle of a turn-off. A design that closed it straight away would short the gate while it still sits at high voltage. The bench also checks that the clamp stays latched after the sense flag drops back, and that it is released on a new turn-on. A design that made the clamp follow the flag combinationally, or forgot to release it, would chatter or fight the pull-up. The bench confirms that a fault leaves no stale clamp state behind. It also confirms that the over-temperature flag is ignored in the build without thermal protection. Finally, it times the dead cycle on both edges, which catches any design that overlaps the two switches or drops the gap.

// File: rtl/gate_drive_seq.sv
module gate_drive_seq #(
  parameter bit OTP_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_pos,
  input  logic cmd_neg,
  input  logic uv_in,
  input  logic uv_out,
  input  logic hot,
  input  logic gate_low,
  output logic pu_en,
  output logic pd_en,
  output logic clamp_en
);

  typedef enum logic [1:0] {S_LOW, S_RISE, S_HIGH, S_FALL} drv_t;

  drv_t st, st_nx;
  logic clamp_q;

  wire req    = cmd_pos & ~cmd_neg;
  wire fault  = uv_in | uv_out | (OTP_EN & hot);
  wire want   = req & ~fault;
  wire off_ph = (st == S_LOW) | (st == S_FALL);

  always_comb begin
    st_nx = st;
    case (st)
      S_LOW:  if (want)  st_nx = S_RISE;
      S_RISE: st_nx = want ? S_HIGH : S_LOW;
      S_HIGH: if (!want) st_nx = S_FALL;
      S_FALL: st_nx = S_LOW;
      default: st_nx = S_LOW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_LOW;
      clamp_q <= 1'b0;
    end else begin
      st <= st_nx;
      if (fault)
        clamp_q <= 1'b0;
      else if (st == S_LOW && want)
        clamp_q <= 1'b0;
      else if (off_ph && gate_low)
        clamp_q <= 1'b1;
    end
  end

  assign pu_en    = (st == S_HIGH);
  assign pd_en    = (st == S_LOW);
  assign clamp_en = clamp_q;

endmodule

// File: rtl/gate_drive_seq_chk.sv
module gate_drive_seq_chk #(
  parameter bit OTP_EN = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_pos,
  input logic cmd_neg,
  input logic uv_in,
  input logic uv_out,
  input logic hot,
  input logic gate_low,
  input logic pu_en,
  input logic pd_en,
  input logic clamp_en
);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(pu_en && pd_en)); // R9
  AST_GAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pu_en) |-> $past(!pd_en)); // R9
  AST_GAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_en) |-> $past(!pu_en)); // R6
  AST_UV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_in || uv_out) |=> !pu_en); // R2
  AST_HOT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (OTP_EN && hot) |=> !pu_en); // R4
  AST_REQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pu_en |-> $past(cmd_pos && !cmd_neg)); // R1
  AST_CLAMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    pu_en |-> !clamp_en); // R8
  AST_CLAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_en && !uv_in && !uv_out && !(OTP_EN && hot) && !(cmd_pos && !cmd_neg)) |=> clamp_en); // R7
  AST_CLAMP_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_in || uv_out) |=> !clamp_en); // R11

endmodule

bind gate_drive_seq gate_drive_seq_chk #(.OTP_EN(OTP_EN)) u_chk (.*);

// File: tb/sim_gate_drive_seq.sv
module sim_gate_drive_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_pos = 0, cmd_neg = 0, uv_in = 1, uv_out = 1, hot = 0, gate_low = 0;
  logic pu_en, pd_en, clamp_en, pu_b, pd_b, cl_b;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gate_drive_seq u0 (.clk, .rst_n, .cmd_pos, .cmd_neg, .uv_in, .uv_out, .hot,
    .gate_low, .pu_en, .pd_en, .clamp_en);
  gate_drive_seq #(.OTP_EN(1'b0)) u1 (.clk, .rst_n, .cmd_pos, .cmd_neg, .uv_in,
    .uv_out, .hot, .gate_low, .pu_en(pu_b), .pd_en(pd_b), .clamp_en(cl_b));

  // {pos,neg,uv_in,uv_out,hot,gate_low, exp pu,pd,clamp}
  localparam logic [8:0] VEC [18] = '{
    9'b10_0000_100, // R1
    9'b00_0000_010, // R1
    9'b11_0000_010, // R1
    9'b01_0000_010, // R1
    9'b10_0000_100, // R3
    9'b10_1000_010, // R2
    9'b10_0100_010, // R2
    9'b10_0000_100, // R3
    9'b10_0010_010, // R4
    9'b10_0000_100, // R4
    9'b00_0001_011, // R7
    9'b00_0000_011, // R7
    9'b01_0000_011, // R7
    9'b10_0000_100, // R8
    9'b00_0001_011, // R7
    9'b00_0101_010, // R11
    9'b00_0000_010, // R11
    9'b10_0001_100  // R7
  };

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act pu/pd/cl=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cmd_pos = 1;
    cyc(2);
    chk("R10 in reset", {pu_en, pd_en, clamp_en}, 3'b010);
    rst_n = 1;
    cyc(3);
    chk("R10 waits for supplies", {pu_en, pd_en, clamp_en}, 3'b010);
    cmd_pos = 0;
    uv_in = 0; uv_out = 0;
    cyc(2);
    for (int i = 0; i < 18; i++) begin
      {cmd_pos, cmd_neg, uv_in, uv_out, hot, gate_low} = VEC[i][8:3];
      cyc(3);
      chk($sformatf("vector %0d", i), {pu_en, pd_en, clamp_en}, VEC[i][2:0]);
    end
    // break-before-make timing: turn-on
    cmd_pos = 0; cmd_neg = 0; gate_low = 0; cyc(3);
    cmd_pos = 1; cyc(1);
    chk("R9 on gap", {pu_en, pd_en, clamp_en}, 3'b000);
    cyc(1);
    chk("R9 on done", {pu_en, pd_en, clamp_en}, 3'b100);
    // turn-off: clamp open at first
    cmd_pos = 0; cyc(1);
    chk("R6 off gap", {pu_en, pd_en, clamp_en}, 3'b000);
    cyc(1);
    chk("R6 pulldown only", {pu_en, pd_en, clamp_en}, 3'b010);
    gate_low = 1; cyc(1);
    chk("R7 latch next clock", {pu_en, pd_en, clamp_en}, 3'b011);
    gate_low = 0;
    cmd_pos = 1; cyc(1);
    chk("R8 release on turn-on", {pu_en, pd_en, clamp_en}, 3'b000);
    cyc(1);
    chk("R8 high no clamp", {pu_en, pd_en, clamp_en}, 3'b100);
    // fault from high: pull-up drops next clock
    uv_out = 1; cyc(1);
    chk("R2 next clock", {pu_en, pd_en}, 2'b00);
    uv_out = 0; cyc(3);
    chk("R3 recover", {pu_en, pd_en}, 2'b10);
    // no thermal variant
    hot = 1; cyc(3);
    chk("R5 variant ignores hot", {pu_b, pd_b, cl_b}, 3'b100);
    chk("R4 protected variant low", {pu_en, pd_en}, 2'b01);
    cmd_pos = 0; gate_low = 1; cyc(3);
    chk("R5 variant clamp unaffected", {pu_b, pd_b, cl_b}, 3'b011);
    hot = 0; gate_low = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule